// File: doc/BRIEF.md
# PLL Clock Switch Sequencer

This block sits between software and the clock tree. It holds the settings that move the core clock from the crystal oscillator onto a multiplied PLL output. Software writes a small byte-wide register file through a simple write port and reads it back combinationally. The block lets through only writes that keep the switch safe. It times the PLL settling interval itself, counted in oscillator cycles. It refuses to route the PLL output to the core until that interval has passed, and it will not allow a fast core clock while the instruction ROM is still in a short access mode.

A rejected write leaves the protected settings untouched and raises a sticky error flag. Software clears the flag by writing a one to it. The analog PLL is not modelled; its settling is represented only by the lock timer. The two clock-enable outputs stand in for the gates of a real clock multiplexer. When the selection changes, they break before they make: both are low for a fixed number of cycles before the new source is enabled.

Top module: `pll_switch_ctrl`

## Requirements
- R1: After reset the PLL control byte reads 0x00, the ROM mode byte reads 0x01 (two-cycle access), the divider byte reads 0x10 (core divide code 0, peripheral divide code 1 = half rate), status reads 0x00, the oscillator enable is 1 and the PLL enable is 0.
- R2: Register map on `bus_addr`: 0 = PLL control (bit 5 select, bit 3 PLL enable, bits 1:0 multiplier code); 1 = ROM access mode in bits 1:0; 2 = divider (core code bits 1:0, peripheral code bits 5:4); 3 = status (bit 0 lock-ready, bit 1 error, bit 2 PLL clock active). Unlisted bits read 0.
- R3: Lock-ready becomes 1 exactly LOCK_CYCLES (OSC_KHZ*LOCK_US/1000) clock edges after an accepted write that changes the enable or multiplier bits while leaving enable at 1. Such a write clears lock-ready at once, and lock-ready is 0 whenever enable is 0.
- R4: Multiplier codes give ratios 00 = x1, 01 = x6, 10 = x4, 11 = x8. The PLL clock counts as fast when OSC_KHZ times the ratio is at least FAST_KHZ.
- R5: A PLL control write that changes enable or multiplier is rejected, and sets the error flag, if select is currently 1 or the same write sets select.
- R6: A write that raises select while lock-ready is 0 is rejected and sets the error flag.
- R7: A write that raises select while the current multiplier is fast and ROM mode bit 1 is 0 (ROM modes: 00 one-cycle, 01 two-cycle, 10 three-cycle, 11 four-cycle) is rejected and sets the error flag.
- R8: A ROM mode write with bit 1 = 0 while select is 1 and the multiplier is fast is rejected and sets the error flag.
- R9: The error flag stays set until a status write with bit 1 = 1. A status write with bit 1 = 0 leaves it unchanged.
- R10: The two clock enables are never both 1. After select changes on a write edge, the old enable drops on the next edge, both stay 0 for SETTLE cycles, and then the new enable rises. Status bit 2 mirrors the PLL enable.
- R11: A write that clears select and changes no other PLL control bit is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| clk_en_osc | output | 1 | Gate enable for the oscillator source |
| clk_en_pll | output | 1 | Gate enable for the PLL source |
| core_div | output | 2 | Core clock divide code |
| io_div | output | 2 | Peripheral clock divide code |

## Verification
The hardest state to reach is a PLL that has settled at a fast ratio while the ROM is still in two-cycle mode. Only from there does the ROM rule decide the outcome, separately from the lock rule. The stimulus enables the x6 ratio and waits out the full lock interval, checking the edge one cycle early and on time. It then attempts the select before reprogramming the ROM. A second pass at the slow x4 ratio with two-cycle ROM shows that the same select goes through when the clock is slow. A behavioural model of the registers, lock timer and gating is compared with the read port and both enables on every clock.

// File: rtl/pllsw_pkg.sv
// Shared constants and helpers for the PLL clock switch sequencer.
// Assumes a byte-wide register port with a two-bit address.
package pllsw_pkg;

    localparam logic [1:0] ADR_PLL  = 2'd0;
    localparam logic [1:0] ADR_ROM  = 2'd1;
    localparam logic [1:0] ADR_DIV  = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    localparam int BIT_SEL = 5;
    localparam int BIT_EN  = 3;

    typedef enum logic [1:0] {
        GS_OSC = 2'd0,
        GS_GAP = 2'd1,
        GS_PLL = 2'd2
    } gate_st_t;

    // Multiplication ratio belonging to a multiplier code.
    function automatic int mul_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 6;
            2'b10:   return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/pllsw_lock_timer.sv
// Lock interval timer: stands in for PLL settling.
// Counts oscillator cycles while the PLL is enabled and saturates at LIMIT.
// Assumes restart is pulsed by any accepted change of enable or multiplier.
module pllsw_lock_timer #(
    parameter int LIMIT = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic restart,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CLIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Advance the settle count, restarting on a configuration change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (pll_en && cnt_q != CLIM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ready = pll_en && (cnt_q == CLIM);

endmodule

// File: rtl/pllsw_regs.sv
// Register file with write guards for the clock switch sequence.
// Rejects unsafe writes to the PLL control and ROM mode registers and records
// them in a sticky error flag. Assumes single-cycle write strobes.
module pllsw_regs
    import pllsw_pkg::*;
#(
    parameter int OSC_KHZ  = 8000,
    parameter int FAST_KHZ = 40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       lock_ready,
    output logic       sel,
    output logic       en,
    output logic [1:0] mul,
    output logic [1:0] rom,
    output logic [1:0] div_core,
    output logic [1:0] div_io,
    output logic       err,
    output logic       cfg_restart
);
    logic       sel_q, en_q, err_q;
    logic [1:0] mul_q, rom_q, dc_q, di_q;
    logic       wr_pll, wr_rom, wr_div, wr_stat;
    logic       cfg_chg, sel_rise, fast_now;
    logic       pll_bad, pll_ok, rom_bad;
    logic       wdata_unused;

    assign wdata_unused = ^{wdata[7:6], wdata[2]};

    // Decode the write target and evaluate the guard rules.
    always_comb begin
        wr_pll   = we && (addr == ADR_PLL);
        wr_rom   = we && (addr == ADR_ROM);
        wr_div   = we && (addr == ADR_DIV);
        wr_stat  = we && (addr == ADR_STAT);
        cfg_chg  = (wdata[BIT_EN] != en_q) || (wdata[1:0] != mul_q);
        sel_rise = wdata[BIT_SEL] && !sel_q;
        fast_now = (OSC_KHZ * mul_ratio(mul_q)) >= FAST_KHZ;
        pll_bad  = wr_pll && ((cfg_chg && (sel_q || wdata[BIT_SEL]))
                            || (sel_rise && !lock_ready)
                            || (sel_rise && fast_now && !rom_q[1]));
        pll_ok   = wr_pll && !pll_bad;
        rom_bad  = wr_rom && sel_q && fast_now && !wdata[1];
    end

    // PLL control register: updated only by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            en_q  <= 1'b0;
            mul_q <= 2'b00;
        end else if (pll_ok) begin
            sel_q <= wdata[BIT_SEL];
            en_q  <= wdata[BIT_EN];
            mul_q <= wdata[1:0];
        end
    end

    // ROM access mode register, starting in two-cycle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rom_q <= 2'b01;
        else if (wr_rom && !rom_bad)
            rom_q <= wdata[1:0];
    end

    // Divider register: core at full rate, peripherals at half rate by default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q <= 2'b00;
            di_q <= 2'b01;
        end else if (wr_div) begin
            dc_q <= wdata[1:0];
            di_q <= wdata[5:4];
        end
    end

    // Sticky error flag: set by a rejected write, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (pll_bad || rom_bad)
            err_q <= 1'b1;
        else if (wr_stat && wdata[1])
            err_q <= 1'b0;
    end

    assign sel         = sel_q;
    assign en          = en_q;
    assign mul         = mul_q;
    assign rom         = rom_q;
    assign div_core    = dc_q;
    assign div_io      = di_q;
    assign err         = err_q;
    assign cfg_restart = pll_ok && cfg_chg;

endmodule

// File: rtl/pllsw_clk_gate.sv
// Break-before-make sequencer for the two clock source enables.
// On a change of the requested source it closes the active gate, waits
// SETTLE cycles with both gates closed, then opens the requested one.
// Assumes SETTLE >= 1. Enables decode straight from the registered state.
module pllsw_clk_gate
    import pllsw_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_pll,
    output logic osc_on,
    output logic pll_on
);
    localparam int SW = $clog2(SETTLE + 1);
    localparam logic [SW-1:0] SLAST = SW'(SETTLE - 1);

    gate_st_t      st_q;
    logic [SW-1:0] gap_q;

    // Step the gate state machine and time the closed gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= GS_OSC;
            gap_q <= '0;
        end else begin
            case (st_q)
                GS_OSC: if (want_pll) begin
                    st_q  <= GS_GAP;
                    gap_q <= '0;
                end
                GS_PLL: if (!want_pll) begin
                    st_q  <= GS_GAP;
                    gap_q <= '0;
                end
                default: begin
                    if (gap_q == SLAST)
                        st_q <= want_pll ? GS_PLL : GS_OSC;
                    else
                        gap_q <= gap_q + 1'b1;
                end
            endcase
        end
    end

    assign osc_on = (st_q == GS_OSC);
    assign pll_on = (st_q == GS_PLL);

endmodule

// File: rtl/pll_switch_ctrl.sv
// Top of the PLL clock switch sequencer.
// Joins the guarded register file, the lock timer and the gate sequencer,
// and drives the combinational read port. One clock domain: the oscillator.
module pll_switch_ctrl
    import pllsw_pkg::*;
#(
    parameter int OSC_KHZ  = 8000,
    parameter int LOCK_US  = 200,
    parameter int FAST_KHZ = 40000,
    parameter int SETTLE   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       clk_en_osc,
    output logic       clk_en_pll,
    output logic [1:0] core_div,
    output logic [1:0] io_div
);
    localparam int LOCK_CYCLES = (OSC_KHZ * LOCK_US) / 1000;

    logic       sel_q, en_q, err_q, lock_ready, restart;
    logic [1:0] mul_q, rom_q;

    pllsw_regs #(
        .OSC_KHZ (OSC_KHZ),
        .FAST_KHZ(FAST_KHZ)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .lock_ready (lock_ready),
        .sel        (sel_q),
        .en         (en_q),
        .mul        (mul_q),
        .rom        (rom_q),
        .div_core   (core_div),
        .div_io     (io_div),
        .err        (err_q),
        .cfg_restart(restart)
    );

    pllsw_lock_timer #(
        .LIMIT(LOCK_CYCLES)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .pll_en (en_q),
        .restart(restart),
        .ready  (lock_ready)
    );

    pllsw_clk_gate #(
        .SETTLE(SETTLE)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_pll(sel_q),
        .osc_on  (clk_en_osc),
        .pll_on  (clk_en_pll)
    );

    // Read multiplexer over the four registers.
    always_comb begin
        case (bus_addr)
            ADR_PLL:  bus_rdata = {2'b00, sel_q, 1'b0, en_q, 1'b0, mul_q};
            ADR_ROM:  bus_rdata = {6'b0, rom_q};
            ADR_DIV:  bus_rdata = {2'b00, io_div, 2'b00, core_div};
            default:  bus_rdata = {5'b0, clk_en_pll, err_q, lock_ready};
        endcase
    end

endmodule

// File: rtl/pllsw_checker.sv
// Property checker for the PLL clock switch sequencer, bound to the top.
// Observes internal register state and the gate outputs; drives nothing.
module pllsw_checker
    import pllsw_pkg::*;
#(
    parameter int OSC_KHZ  = 8000,
    parameter int FAST_KHZ = 40000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic       sel,
    input logic       en,
    input logic [1:0] mul,
    input logic [1:0] rom,
    input logic       lock_ready,
    input logic       err,
    input logic       osc_on,
    input logic       pll_on
);
    logic fast;
    assign fast = (OSC_KHZ * mul_ratio(mul)) >= FAST_KHZ;

    AST_GATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_on && pll_on)); // R10
    AST_GAP_BEFORE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_on) |-> $past(!osc_on && !pll_on)); // R10
    AST_SEL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> $past(lock_ready)); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> ($stable(en) && $stable(mul))); // R5
    AST_ROM_SLOW_WHEN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && fast) |-> rom[1]); // R7
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(bus_we)); // R9

endmodule

bind pll_switch_ctrl pllsw_checker #(
    .OSC_KHZ (OSC_KHZ),
    .FAST_KHZ(FAST_KHZ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .sel       (sel_q),
    .en        (en_q),
    .mul       (mul_q),
    .rom       (rom_q),
    .lock_ready(lock_ready),
    .err       (err_q),
    .osc_on    (clk_en_osc),
    .pll_on    (clk_en_pll)
);

// File: tb/pll_switch_ctrl_bench.sv
// Bench: behavioural reference compared every clock, plus directed checks.
module pll_switch_ctrl_bench;
    localparam int OSC = 8000;
    localparam int L   = OSC * 200 / 1000;
    localparam int S   = 2;
    localparam int FAST = 40000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       clk_en_osc, clk_en_pll;
    logic [1:0] core_div, io_div;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    pll_switch_ctrl u_pll_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_en_osc(clk_en_osc), .clk_en_pll(clk_en_pll),
        .core_div(core_div), .io_div(io_div)
    );

    always #10 clk = ~clk;

    // Reference state: plain integers.
    int m_sel, m_en, m_mul, m_rom, m_dc, m_di, m_err, m_cnt, g_st, g_cnt;

    function automatic int ratio(int code);
        case (code)
            0: return 1;
            1: return 6;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        int v;
        case (a)
            0: v = m_sel * 32 + m_en * 8 + m_mul;
            1: v = m_rom;
            2: v = m_di * 16 + m_dc;
            default: v = (g_st == 2 ? 4 : 0) + m_err * 2
                         + ((m_en != 0 && m_cnt == L) ? 1 : 0);
        endcase
        return 8'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_en = 0; m_mul = 0; m_rom = 1; m_dc = 0; m_di = 1;
            m_err = 0; m_cnt = 0; g_st = 0; g_cnt = 0;
        end else begin
            int  lk, fast, chg, bad, rst_cnt, wsel;
            lk = (m_en != 0 && m_cnt == L);
            fast = (OSC * ratio(m_mul) >= FAST);
            rst_cnt = 0;
            // gates follow the select value from before this edge
            if (g_st == 0 && m_sel != 0) begin g_st = 1; g_cnt = 0; end
            else if (g_st == 2 && m_sel == 0) begin g_st = 1; g_cnt = 0; end
            else if (g_st == 1) begin
                if (g_cnt == S - 1) g_st = (m_sel != 0) ? 2 : 0;
                else g_cnt++;
            end
            if (m_en != 0 && m_cnt < L) m_cnt++;
            if (bus_we) begin
                case (bus_addr)
                    0: begin
                        wsel = bus_wdata[5];
                        chg = (bus_wdata[3] != m_en) || (bus_wdata[1:0] != m_mul);
                        bad = (chg && (m_sel != 0 || wsel != 0))
                           || (wsel != 0 && m_sel == 0 && !lk)
                           || (wsel != 0 && m_sel == 0 && fast && m_rom < 2);
                        if (bad) m_err = 1;
                        else begin
                            m_sel = wsel; m_en = bus_wdata[3]; m_mul = bus_wdata[1:0];
                            rst_cnt = chg;
                        end
                    end
                    1: if (m_sel != 0 && fast && bus_wdata[1] == 0) m_err = 1;
                       else m_rom = bus_wdata[1:0];
                    2: begin m_dc = bus_wdata[1:0]; m_di = bus_wdata[5:4]; end
                    default: if (bus_wdata[1]) m_err = 0;
                endcase
            end
            if (rst_cnt != 0) m_cnt = 0;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Every-clock comparison against the reference, mid-cycle.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk("R10 gates", {6'b0, clk_en_osc, clk_en_pll},
                {6'b0, (g_st == 0) ? 1'b1 : 1'b0, (g_st == 2) ? 1'b1 : 1'b0});
            chk("R2 readback", bus_rdata, exp_rd(bus_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_up();
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic gates(string req, logic o, logic p);
        chk(req, {6'b0, clk_en_osc, clk_en_pll}, {6'b0, o, p});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek("R1 pll", 2'd0, 8'h00);
        peek("R1 rom", 2'd1, 8'h01);
        peek("R1 div", 2'd2, 8'h10);
        peek("R1 stat", 2'd3, 8'h00);
        gates("R1 gates", 1'b1, 1'b0);
        chk("R1 divider ports", {2'b0, io_div, 2'b0, core_div}, 8'h10);

        // R6 select with no lock
        wr(2'd0, 8'h20);
        peek("R6 pll kept", 2'd0, 8'h00);
        peek("R6 err set", 2'd3, 8'h02);
        // R9 sticky flag, write-one-to-clear
        wr(2'd3, 8'h00);
        peek("R9 kept", 2'd3, 8'h02);
        wr(2'd3, 8'h02);
        peek("R9 cleared", 2'd3, 8'h00);

        // R3 lock timing at x6 (R4: 48 MHz is fast)
        wr(2'd0, 8'h09);
        peek("R2 pll write", 2'd0, 8'h09);
        repeat (L - 1) @(negedge clk);
        peek("R3 not yet", 2'd3, 8'h00);
        @(negedge clk);
        peek("R3 ready", 2'd3, 8'h01);

        // R7 fast clock with two-cycle ROM
        wr(2'd0, 8'h29);
        peek("R7 pll kept", 2'd0, 8'h09);
        peek("R7 err", 2'd3, 8'h03);
        wr(2'd3, 8'h02);
        // R5 select together with a multiplier change
        wr(2'd0, 8'h2A);
        peek("R5 pll kept", 2'd0, 8'h09);
        peek("R5 err", 2'd3, 8'h03);
        wr(2'd3, 8'h02);

        // ROM to three-cycle, then a legal switch; R10 break-before-make
        wr(2'd1, 8'h02);
        peek("R2 rom", 2'd1, 8'h02);
        wr(2'd0, 8'h29);
        gates("R10 old held", 1'b1, 1'b0);
        @(negedge clk);
        gates("R10 gap1", 1'b0, 1'b0);
        @(negedge clk);
        gates("R10 gap2", 1'b0, 1'b0);
        @(negedge clk);
        gates("R10 pll on", 1'b0, 1'b1);
        peek("R10 status", 2'd3, 8'h05);

        // R8 ROM lowered while fast clock selected
        wr(2'd1, 8'h01);
        peek("R8 rom kept", 2'd1, 8'h02);
        peek("R8 err", 2'd3, 8'h07);
        wr(2'd3, 8'h02);
        // R5 multiplier change while selected, and with select clear
        wr(2'd0, 8'h2B);
        peek("R5 sel held", 2'd0, 8'h29);
        wr(2'd0, 8'h0B);
        peek("R5 clear+chg", 2'd0, 8'h29);
        peek("R5 err2", 2'd3, 8'h07);
        wr(2'd3, 8'h02);

        // R11 plain deselect
        wr(2'd0, 8'h09);
        peek("R11 pll", 2'd0, 8'h09);
        repeat (3) @(negedge clk);
        gates("R11 back on osc", 1'b1, 1'b0);

        // R4 slow ratio x4 lets two-cycle ROM through; R3 restart
        wr(2'd0, 8'h0A);
        peek("R3 restart", 2'd3, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h31);
        chk("R2 div ports", {2'b0, io_div, 2'b0, core_div}, 8'h31);
        repeat (L + 2) @(negedge clk);
        wr(2'd0, 8'h2A);
        peek("R4 slow accepted", 2'd0, 8'h2A);
        repeat (4) @(negedge clk);
        peek("R4 status", 2'd3, 8'h05);

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule